// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block is the software-facing register file of a multi-channel DMA controller. A 32-bit memory-mapped bus reaches a set of per-channel registers. Every channel occupies its own 8 KiB window, and inside that window a word index selects one register. The unit stores the descriptor pointers and the channel configuration. It keeps a one-hot channel state that follows configuration writes and start events from the channel engine. It builds a read-only status word and maintains raw and masked interrupt bits with a self-clearing acknowledge. It drives one interrupt line per channel.

The channel engine sits beside this unit and does the descriptor fetch and the data transfer. It receives single-cycle pulses when software writes the continue register or the stream-command register. It reports back start events, the end-of-list condition, the command-source field and interrupt set requests.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel is `bus_addr[ADDR_W-1:13]` and the register word index is `bus_addr[7:2]`. Address bits 12:8 and 1:0 are ignored. When the channel field is NUM_CH or above, reads return 0 and writes have no effect.
- R2: After reset, the status word of each channel reads 0x0000_0101 (state reset, source field 1). Configuration, command, mask, stream-command and raw interrupt read 0, and every `irq` bit is low.
- R3: The channel state is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. A configuration write (index 33, byte offset 0x84) with bit 1 set selects stopped. If bit 0 of the same write is clear, the state becomes reset, and this rule wins over the bit 1 rule. With bit 0 set and bit 1 clear, the state is unchanged.
- R4: A pulse on `eng_start[c]` puts channel c into running only when its stored configuration has bit 0 = 1 and bit 1 = 0. A configuration write in the same cycle takes precedence.
- R5: The status word (index 34, offset 0x88) holds the state in bits 2:0, `eng_eol[c]` in bit 5 and the command-source byte in bits 15:8. The source byte loads from `eng_src` when `eng_src_load[c]` pulses. All other bits read 0.
- R6: Bits of `eng_irq_set` are ORed into the raw interrupt register (index 37, offset 0x94). A write to acknowledge (index 36, offset 0x90) clears the raw bits that are set in the written value. Acknowledge always reads 0. A set request in the same cycle as an acknowledge of the same bit leaves that bit set.
- R7: The masked register (index 38, offset 0x98) reads raw AND mask, where the mask is at index 35 (offset 0x8C). `irq[c]` is the OR of channel c's masked bits. A mask write never alters the raw bits.
- R8: A word write to the continue register (index 32, offset 0x80) raises `cont_pulse[c]` for exactly one cycle, one cycle after the write. If any written bit above bit 0 is set, `cmd_bad` pulses in the same cycle. The written value reads back.
- R9: A word write to the stream-command register (index 39, offset 0x9C) raises `strm_pulse[c]` one cycle later, with `strm_cmd` = written bits 9:0. If any bit above bit 9 is set, `cmd_bad` pulses.
- R10: An access with `bus_size` other than 2'b10 (word) gives a one-cycle `bus_err` pulse on the next cycle and changes no register. A read of that kind still returns `bus_rvalid` with data 0.
- R11: Descriptor pointers at indices 0, 22, 23, 24 and 31 (offsets 0x00, 0x58, 0x5C, 0x60, 0x7C) store and return all 32 bits. Writes to status, raw and masked are ignored. Undefined indices read 0 and ignore writes.
- R12: Every read gives `bus_rvalid` and `bus_rdata` exactly one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Narrow access rejected |
| eng_start | input | NUM_CH | Engine start event per channel |
| eng_eol | input | NUM_CH | End-of-list flag per channel |
| eng_src_load | input | NUM_CH | Load strobe for the command-source byte |
| eng_src | input | NUM_CH*8 | Command-source byte per channel |
| eng_irq_set | input | NUM_CH*IRQ_W | Raw interrupt set requests per channel |
| chan_state | output | NUM_CH*3 | One-hot state per channel |
| cont_pulse | output | NUM_CH | Continue command pulse per channel |
| strm_pulse | output | NUM_CH | Stream command pulse per channel |
| strm_cmd | output | 10 | Stream command code, valid with strm_pulse |
| cmd_bad | output | 1 | Command written with reserved bits set |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
The bench tries configuration writes that set both control bits and checks that the reset rule wins. If the priority were reversed, the status would read stopped instead of reset. It acknowledges one bit of two, then acknowledges in the same cycle as a new set request. A design that lost the new event, or cleared the wrong bits, would drop `irq` or show stale raw bits. It also sends narrow writes, an aliased address with bits 12:8 set, and a channel field past the last channel. A loose decoder would corrupt a neighbouring channel or accept the narrow write. Reserved command bits are checked on both command registers, since a decoder that tests the wrong width would miss `cmd_bad` or raise it falsely.

// File: rtl/dmacr_pkg.sv
// Shared types, register indices and helpers for the DMA channel register unit.
// Assumes a 32-bit data bus and a 6-bit register word index per channel.
package dmacr_pkg;

    localparam int REG_W = 32;
    localparam int IDX_W = 6;
    localparam int WIN_LSB = 13;
    localparam int NPTR = 5;

    typedef enum logic [2:0] {
        ST_RST  = 3'b001,
        ST_STOP = 3'b010,
        ST_RUN  = 3'b100
    } chan_state_t;

    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [IDX_W-1:0] RIX_CMD    = 6'd32;
    localparam logic [IDX_W-1:0] RIX_CFG    = 6'd33;
    localparam logic [IDX_W-1:0] RIX_STAT   = 6'd34;
    localparam logic [IDX_W-1:0] RIX_MASK   = 6'd35;
    localparam logic [IDX_W-1:0] RIX_ACK    = 6'd36;
    localparam logic [IDX_W-1:0] RIX_RAW    = 6'd37;
    localparam logic [IDX_W-1:0] RIX_MASKED = 6'd38;
    localparam logic [IDX_W-1:0] RIX_STRM   = 6'd39;

    // Pointer slots: data, saved data, saved buffer, group, group-down.
    localparam logic [IDX_W-1:0] PTR_IDX [NPTR] = '{6'd0, 6'd22, 6'd23, 6'd24, 6'd31};

    // State after a configuration write; the reset rule is applied last so it wins.
    function automatic chan_state_t cfg_state(chan_state_t cur, logic [1:0] cfg);
        chan_state_t nxt;
        nxt = cur;
        if (cfg[1]) nxt = ST_STOP;
        if (!cfg[0]) nxt = ST_RST;
        return nxt;
    endfunction

endpackage

// File: rtl/dmacr_decode.sv
// Address decoder: splits the bus address into a one-hot channel select and a
// register word index, and classifies the access by size.
// Assumes one access per cycle and ADDR_W > 13.
module dmacr_decode
    import dmacr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic [NUM_CH-1:0] ch_sel,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic              narrow
);
    localparam int CF_W = ADDR_W - WIN_LSB;

    logic [CF_W-1:0] ch_field;
    logic            word_acc;
    logic            addr_unused;

    // Field extraction; bits 12:8 and 1:0 take no part in decode.
    assign ch_field    = bus_addr[ADDR_W-1:WIN_LSB];
    assign reg_idx     = bus_addr[7:2];
    assign addr_unused = ^{bus_addr[12:8], bus_addr[1:0]};

    // Access classification by size.
    assign word_acc = (bus_size == SZ_WORD);
    assign narrow   = (bus_wr | bus_rd) & ~word_acc;
    assign wr_hit   = bus_wr & word_acc;
    assign rd_hit   = bus_rd & word_acc;

    // One select line per implemented channel; out-of-range fields select none.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign ch_sel[c] = (ch_field == CF_W'(c));
    end

endmodule

// File: rtl/dmacr_chan.sv
// Register set for one DMA channel: descriptor pointers, configuration,
// command registers, one-hot state, status word and interrupt combine.
// Assumes wr_en is already qualified by channel select and word size.
module dmacr_chan
    import dmacr_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    input  logic             eng_start,
    input  logic             eng_eol,
    input  logic             src_load,
    input  logic [7:0]       src_in,
    input  logic [IRQ_W-1:0] irq_set,
    output logic [REG_W-1:0] rd_word,
    output logic [2:0]       state_o,
    output logic             cont_fire,
    output logic             strm_fire,
    output logic             bad_fire,
    output logic             irq
);
    localparam int PAD_W = REG_W - IRQ_W;

    logic [REG_W-1:0] ptr_q [NPTR];
    logic [REG_W-1:0] cmd_q;
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] strm_q;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] raw_q;
    logic [7:0]       src_q;
    chan_state_t      state_q;

    logic             wr_cmd, wr_cfg, wr_mask, wr_ack, wr_strm;
    logic [IRQ_W-1:0] ack_bits;
    logic [IRQ_W-1:0] masked;

    // Per-register write strobes.
    assign wr_cmd  = wr_en && (idx == RIX_CMD);
    assign wr_cfg  = wr_en && (idx == RIX_CFG);
    assign wr_mask = wr_en && (idx == RIX_MASK);
    assign wr_ack  = wr_en && (idx == RIX_ACK);
    assign wr_strm = wr_en && (idx == RIX_STRM);
    assign ack_bits = wr_ack ? wdata[IRQ_W-1:0] : '0;

    // Descriptor pointer storage, one register per slot.
    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[k] <= '0;
            else if (wr_en && (idx == PTR_IDX[k]))
                ptr_q[k] <= wdata;
        end
    end

    // Configuration, command and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cmd_q  <= '0;
            strm_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_cfg)  cfg_q  <= wdata;
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_strm) strm_q <= wdata;
            if (wr_mask) mask_q <= wdata[IRQ_W-1:0];
        end
    end

    // Channel state: configuration writes first, then engine start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RST;
        else if (wr_cfg)
            state_q <= cfg_state(state_q, wdata[1:0]);
        else if (eng_start && cfg_q[0] && !cfg_q[1])
            state_q <= ST_RUN;
    end

    // Command-source byte latched from the engine.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= 8'h01;
        else if (src_load)
            src_q <= src_in;
    end

    // Raw interrupts: acknowledge clears, engine sets win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~ack_bits) | irq_set;
    end

    // Command pulses and reserved-bit flag toward the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_fire <= 1'b0;
            strm_fire <= 1'b0;
            bad_fire  <= 1'b0;
        end else begin
            cont_fire <= wr_cmd;
            strm_fire <= wr_strm;
            bad_fire  <= (wr_cmd && (wdata[REG_W-1:1] != '0)) ||
                         (wr_strm && (wdata[REG_W-1:10] != '0));
        end
    end

    // Interrupt combine.
    assign masked  = raw_q & mask_q;
    assign irq     = |masked;
    assign state_o = state_q;

    // Read word selection for this channel.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NPTR; k++)
            if (idx == PTR_IDX[k]) rd_word = ptr_q[k];
        case (idx)
            RIX_CMD:    rd_word = cmd_q;
            RIX_CFG:    rd_word = cfg_q;
            RIX_STAT:   rd_word = {16'h0000, src_q, 2'b00, eng_eol, 2'b00, state_q};
            RIX_MASK:   rd_word = {{PAD_W{1'b0}}, mask_q};
            RIX_RAW:    rd_word = {{PAD_W{1'b0}}, raw_q};
            RIX_MASKED: rd_word = {{PAD_W{1'b0}}, masked};
            RIX_STRM:   rd_word = strm_q;
            default:    ;
        endcase
    end

endmodule

// File: rtl/dmacr_rdmux.sv
// Read return path: picks the selected channel's word and registers it with
// a valid flag one cycle after the read strobe.
// Assumes ch_sel is one-hot or zero.
module dmacr_rdmux
    import dmacr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_any,
    input  logic                    rd_hit,
    input  logic [NUM_CH-1:0]       ch_sel,
    input  logic [NUM_CH*REG_W-1:0] words,
    output logic [REG_W-1:0]        rdata,
    output logic                    rvalid
);
    logic [REG_W-1:0] pick;

    // OR-combine of the selected channel word.
    always_comb begin
        pick = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (ch_sel[c]) pick = pick | words[c*REG_W +: REG_W];
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_any;
            rdata  <= rd_hit ? pick : '0;
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Top of the DMA channel register unit: decoder, one register set per
// channel, read return path, error flag and stream code latch.
// Assumes one bus access per cycle, one-cycle strobes and ADDR_W > 13.
module dma_chan_regs
    import dmacr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int IRQ_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    output logic                    bus_err,
    input  logic [NUM_CH-1:0]       eng_start,
    input  logic [NUM_CH-1:0]       eng_eol,
    input  logic [NUM_CH-1:0]       eng_src_load,
    input  logic [NUM_CH*8-1:0]     eng_src,
    input  logic [NUM_CH*IRQ_W-1:0] eng_irq_set,
    output logic [NUM_CH*3-1:0]     chan_state,
    output logic [NUM_CH-1:0]       cont_pulse,
    output logic [NUM_CH-1:0]       strm_pulse,
    output logic [9:0]              strm_cmd,
    output logic                    cmd_bad,
    output logic [NUM_CH-1:0]       irq
);
    logic [NUM_CH-1:0]       ch_sel;
    logic [IDX_W-1:0]        reg_idx;
    logic                    wr_hit, rd_hit, narrow;
    logic [NUM_CH*REG_W-1:0] words;
    logic [NUM_CH-1:0]       bad_vec;
    logic                    strm_wr;

    dmacr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .ch_sel   (ch_sel),
        .reg_idx  (reg_idx),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit),
        .narrow   (narrow)
    );

    // One register set per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmacr_chan #(.IRQ_W(IRQ_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_hit && ch_sel[c]),
            .idx       (reg_idx),
            .wdata     (bus_wdata),
            .eng_start (eng_start[c]),
            .eng_eol   (eng_eol[c]),
            .src_load  (eng_src_load[c]),
            .src_in    (eng_src[c*8 +: 8]),
            .irq_set   (eng_irq_set[c*IRQ_W +: IRQ_W]),
            .rd_word   (words[c*REG_W +: REG_W]),
            .state_o   (chan_state[c*3 +: 3]),
            .cont_fire (cont_pulse[c]),
            .strm_fire (strm_pulse[c]),
            .bad_fire  (bad_vec[c]),
            .irq       (irq[c])
        );
    end

    dmacr_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_any (bus_rd),
        .rd_hit (rd_hit),
        .ch_sel (ch_sel),
        .words  (words),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    assign strm_wr = wr_hit && (|ch_sel) && (reg_idx == RIX_STRM);
    assign cmd_bad = |bad_vec;

    // Narrow-access error flag and stream code latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err  <= 1'b0;
            strm_cmd <= '0;
        end else begin
            bus_err <= narrow;
            if (strm_wr) strm_cmd <= bus_wdata[9:0];
        end
    end

endmodule

// File: rtl/dmacr_check.sv
// Property checker for the DMA channel register unit, bound to the top.
// Assumes the top's default bus framing: one-cycle strobes.
module dmacr_check #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int IRQ_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [1:0]              bus_size,
    input logic [31:0]             bus_wdata,
    input logic                    bus_err,
    input logic                    bus_rvalid,
    input logic [NUM_CH-1:0]       cont_pulse,
    input logic [NUM_CH*3-1:0]     chan_state,
    input logic [NUM_CH*IRQ_W-1:0] eng_irq_set,
    input logic [NUM_CH-1:0]       irq
);
    logic ch0_word_wr;
    assign ch0_word_wr = bus_wr && (bus_size == 2'b10) && (bus_addr[ADDR_W-1:13] == '0);

    // R3: each channel state is always one-hot.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_oh
        p_state_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(chan_state[c*3 +: 3]) == 1);
    end

    // R3: config write with bit 0 clear returns channel 0 to reset.
    p_cfg_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_word_wr && bus_addr[7:2] == 6'd33 && !bus_wdata[0]) |=> (chan_state[2:0] == 3'b001));

    // R6: acknowledging every bit with no new set drops the line.
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_word_wr && bus_addr[7:2] == 6'd36 && (&bus_wdata[IRQ_W-1:0]) &&
         eng_irq_set[IRQ_W-1:0] == '0) |=> !irq[0]);

    // R8: continue write yields a pulse next cycle.
    p_cont_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_word_wr && bus_addr[7:2] == 6'd32) |=> cont_pulse[0]);

    // R10: narrow access raises the error flag next cycle.
    p_narrow_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_size != 2'b10) |=> bus_err);

    // R12: read response arrives one cycle later.
    p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

endmodule

bind dma_chan_regs dmacr_check #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_dmacr_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .bus_err     (bus_err),
    .bus_rvalid  (bus_rvalid),
    .cont_pulse  (cont_pulse),
    .chan_state  (chan_state),
    .eng_irq_set (eng_irq_set),
    .irq         (irq)
);

// File: tb/test_dma_chan_regs.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them as read responses appear.
module test_dma_chan_regs;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 16;
    localparam int IRQ_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0] bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid, bus_err;
    logic [NUM_CH-1:0] eng_start = '0, eng_eol = '0, eng_src_load = '0;
    logic [NUM_CH*8-1:0] eng_src = '0;
    logic [NUM_CH*IRQ_W-1:0] eng_irq_set = '0;
    logic [NUM_CH*3-1:0] chan_state;
    logic [NUM_CH-1:0] cont_pulse, strm_pulse, irq;
    logic [9:0] strm_cmd;
    logic cmd_bad;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic [NUM_CH-1:0] s_cont, s_strm;
    logic s_bad, s_err;
    logic [9:0] s_scmd;

    always #10 clk = ~clk;

    dma_chan_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .eng_start(eng_start), .eng_eol(eng_eol), .eng_src_load(eng_src_load),
        .eng_src(eng_src), .eng_irq_set(eng_irq_set), .chan_state(chan_state),
        .cont_pulse(cont_pulse), .strm_pulse(strm_pulse), .strm_cmd(strm_cmd),
        .cmd_bad(cmd_bad), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'b10;
        s_cont = cont_pulse; s_strm = strm_pulse; s_bad = cmd_bad;
        s_err = bus_err; s_scmd = strm_cmd;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req,
                      input logic [1:0] sz = 2'b10);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(req);
        bus_rd = 1'b1; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = 2'b10;
    endtask

    // Monitor: compare each read response against the queue (R12).
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R12 actual=unexpected response expected=none");
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset values
        rd(16'h0088, 32'h101, "R2 status reset");
        rd(16'h0084, 32'h0, "R2 config reset");
        rd(16'h0094, 32'h0, "R2 raw reset");
        chk("R2 irq reset", {28'h0, irq}, 32'h0);

        // R3 / R4 state machine on channel 1
        wr(16'h2084, 32'h1);
        rd(16'h2088, 32'h101, "R3 bit0 set keeps reset");
        @(negedge clk); eng_start[1] = 1'b1; @(negedge clk); eng_start[1] = 1'b0;
        rd(16'h2088, 32'h104, "R4 start to running");
        wr(16'h2084, 32'h3);
        rd(16'h2088, 32'h102, "R3 bit1 stops");
        wr(16'h2084, 32'h2);
        rd(16'h2088, 32'h101, "R3 bit0 clear wins");
        @(negedge clk); eng_start[1] = 1'b1; @(negedge clk); eng_start[1] = 1'b0;
        rd(16'h2088, 32'h101, "R4 start ignored when disabled");

        // R5 status composition on channel 2
        @(negedge clk); eng_eol[2] = 1'b1; eng_src[23:16] = 8'h5A; eng_src_load[2] = 1'b1;
        @(negedge clk); eng_src_load[2] = 1'b0;
        rd(16'h4088, 32'h5A21, "R5 status fields");

        // R6 / R7 interrupts on channel 0
        wr(16'h008C, 32'h4);
        @(negedge clk); eng_irq_set[3:0] = 4'h6; @(negedge clk); eng_irq_set[3:0] = 4'h0;
        rd(16'h0094, 32'h6, "R6 raw set");
        rd(16'h0098, 32'h4, "R7 masked");
        chk("R7 irq asserted", {31'h0, irq[0]}, 32'h1);
        wr(16'h0090, 32'h2);
        rd(16'h0094, 32'h4, "R6 partial ack");
        rd(16'h0090, 32'h0, "R6 ack reads zero");
        chk("R7 irq stays", {31'h0, irq[0]}, 32'h1);
        wr(16'h0090, 32'h4);
        chk("R7 irq cleared", {31'h0, irq[0]}, 32'h0);
        rd(16'h0098, 32'h0, "R7 masked cleared");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h0090; bus_wdata = 32'h1; eng_irq_set[3:0] = 4'h1;
        @(negedge clk);
        bus_wr = 1'b0; eng_irq_set[3:0] = 4'h0;
        rd(16'h0094, 32'h1, "R6 set wins over ack");
        wr(16'h008C, 32'h0);
        chk("R7 mask off drops irq", {31'h0, irq[0]}, 32'h0);
        rd(16'h0094, 32'h1, "R7 mask write keeps raw");

        // R8 continue command on channel 3
        wr(16'h6080, 32'h1);
        chk("R8 cont pulse", {28'h0, s_cont}, 32'h8);
        chk("R8 no bad", {31'h0, s_bad}, 32'h0);
        wr(16'h6080, 32'h3);
        chk("R8 reserved flagged", {31'h0, s_bad}, 32'h1);
        rd(16'h6080, 32'h3, "R8 readback");

        // R9 stream command on channel 1
        wr(16'h209C, 32'h240);
        chk("R9 strm pulse", {28'h0, s_strm}, 32'h2);
        chk("R9 strm code", {22'h0, s_scmd}, 32'h240);
        chk("R9 no bad", {31'h0, s_bad}, 32'h0);
        wr(16'h209C, 32'h400);
        chk("R9 reserved flagged", {31'h0, s_bad}, 32'h1);

        // R10 narrow accesses
        wr(16'h0084, 32'h3, 2'b00);
        chk("R10 write error", {31'h0, s_err}, 32'h1);
        rd(16'h0084, 32'h0, "R10 narrow write ignored");
        rd(16'h0088, 32'h0, "R10 narrow read zero", 2'b01);

        // R1 decode: alias bits and out-of-range channel
        wr(16'h0184, 32'h1);
        rd(16'h0084, 32'h1, "R1 alias bits ignored");
        wr(16'hA084, 32'h3);
        rd(16'hA084, 32'h0, "R1 out-of-range read zero");
        rd(16'h2084, 32'h2, "R1 out-of-range write ignored");

        // R11 pointers and undefined / read-only indices
        wr(16'h0058, 32'hDEADBEEF);
        rd(16'h0058, 32'hDEADBEEF, "R11 saved pointer");
        wr(16'h607C, 32'h12345678);
        rd(16'h607C, 32'h12345678, "R11 group-down pointer");
        wr(16'h0014, 32'hFFFF);
        rd(16'h0014, 32'h0, "R11 undefined index");
        wr(16'h0094, 32'hF);
        rd(16'h0094, 32'h1, "R11 raw write ignored");
        wr(16'h0088, 32'h0);
        rd(16'h0088, 32'h101, "R11 status write ignored");
        rd(16'h00C8, 32'h0, "R11 high index zero");

        repeat (3) @(negedge clk);
        chk("R12 all reads answered", exp_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule